// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Status Flags

This block takes an asynchronous serial line that idles high. It turns each character on that line into a parallel byte. Timing comes from a one-cycle `tick` enable that runs at sixteen times the bit rate. The line passes through a two-flop synchronizer. A falling edge arms the start-bit check, which samples near the centre of the start bit. Each following bit is sampled sixteen ticks after the one before it, least significant bit first. The optional parity bit and the first stop bit come next.

When the first stop bit is sampled, the character is copied into an 8-bit holding register. It is right-justified and its unused upper bits are zero. The overrun flag is updated at that same moment. On the next tick, data-ready rises and the framing and parity flags are updated. On that tick the receiver is also armed again for the next start bit. That tick falls nine ticks into the first stop bit, so characters sent back to back are accepted.

The character format is held in a control word. It is captured only while `cfg_load` is high. Software empties the holding register by pulling `dr_clr_n` low.

Top module: `uart_rx_core`

## Requirements
- R1: After reset and before any character arrives, `rx_data` is 0 and `data_ready`, `overrun`, `frame_err` and `parity_err` are all low.
- R2: A start is accepted only when a falling edge on the line is still low at the start-bit centre sample. A shorter low pulse leaves `rx_data` and every flag unchanged, and the next real character is received correctly.
- R3: Data bits arrive least significant bit first. The character length is 5, 6, 7 or 8 bits for `cfg_len` = 0, 1, 2, 3. `rx_data` holds the character in its low bits, with all higher bits zero.
- R4: With `cfg_par_off` = 0, `parity_err` is high when the number of ones over the data bits and the parity bit is odd (`cfg_par_even` = 1) or even (`cfg_par_even` = 0). With `cfg_par_off` = 1, no parity bit is expected and `parity_err` is low.
- R5: `frame_err` is high exactly when the sampled first stop bit is low.
- R6: `overrun` is set, at the moment of the copy, when `data_ready` was still high. It is cleared when the previous character had been taken. `rx_data` changes before `data_ready` rises.
- R7: While `dr_clr_n` is low, `data_ready` is cleared on the next clock unless a new character completes on that cycle.
- R8: `data_ready`, `frame_err` and `parity_err` change one tick after the copy, and the receiver accepts a start edge that comes straight after a 16-tick stop bit.
- R9: The format fields are captured only while `cfg_load` is high. Changing them at other times does not change how characters are received.
- R10: Reset clears the holding register, all flags and the control word. The cleared control word means 5-bit characters with odd parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| cfg_load | input | 1 | Captures the format fields while high |
| cfg_len | input | 2 | Character length code: 0..3 gives 5..8 bits |
| cfg_par_off | input | 1 | 1: no parity bit in the frame |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| dr_clr_n | input | 1 | Active-low clear of data-ready |
| rx_data | output | 8 | Received character, right-justified |
| data_ready | output | 1 | A new character is in `rx_data` |
| overrun | output | 1 | The last character replaced one that had not been taken |
| frame_err | output | 1 | The first stop bit of the last character was low |
| parity_err | output | 1 | The parity of the last character did not match |

## Verification
The properties assume that `tick` is a single-clock pulse separated by idle clocks. They also assume that `cfg_load` is raised only between characters, since the right-justification check compares `rx_data` with the captured length. The stimulus raises `tick` on one clock in four and moves the serial line only on the falling clock edge just after a tick. It changes the format only while the line idles, and it pulses `dr_clr_n` only between characters. Seeded random characters cover every length and parity setting and include corrupted parity and stop bits. Directed runs add short glitches, back-to-back frames and format changes made without `cfg_load`.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       cfg_load,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_off,
  input  logic       cfg_par_even,
  input  logic       dr_clr_n,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overrun,
  output logic       frame_err,
  output logic       parity_err
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] HALF = CW'(OS / 2 - 2);
  localparam logic [CW-1:0] FULL = CW'(OS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FLAG} st_t;

  st_t st;
  logic [1:0]    sync;
  logic          rx_prev;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          pbit, stop_ok;
  logic [1:0]    len_q;
  logic          par_off_q, par_even_q;

  wire       rxs      = sync[1];
  wire [2:0] last_idx = 3'd4 + {1'b0, len_q};
  wire [7:0] aligned  = sh >> (2'd3 - len_q);
  wire       par_bad  = (^rx_data) ^ pbit ^ ~par_even_q;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      rx_prev <= 1'b1;
      cnt <= '0;
      idx <= '0;
      sh <= '0;
      pbit <= 1'b0;
      stop_ok <= 1'b1;
      len_q <= '0;
      par_off_q <= 1'b0;
      par_even_q <= 1'b0;
      rx_data <= '0;
      data_ready <= 1'b0;
      overrun <= 1'b0;
      frame_err <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      if (cfg_load) begin
        len_q <= cfg_len;
        par_off_q <= cfg_par_off;
        par_even_q <= cfg_par_even;
      end
      if (!dr_clr_n) data_ready <= 1'b0;
      if (tick) begin
        rx_prev <= rxs;
        case (st)
          S_IDLE:
            if (rx_prev && !rxs) begin
              st <= S_START;
              cnt <= '0;
            end
          S_START:
            if (cnt == HALF) begin
              cnt <= '0;
              idx <= '0;
              st <= rxs ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt == FULL) begin
              cnt <= '0;
              sh <= {rxs, sh[7:1]};
              idx <= idx + 1'b1;
              if (idx == last_idx) st <= par_off_q ? S_STOP : S_PAR;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (cnt == FULL) begin
              cnt <= '0;
              pbit <= rxs;
              st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt == FULL) begin
              cnt <= '0;
              rx_data <= aligned;
              overrun <= data_ready && dr_clr_n;
              stop_ok <= rxs;
              st <= S_FLAG;
            end else cnt <= cnt + 1'b1;
          S_FLAG: begin
            data_ready <= 1'b1;
            frame_err <= !stop_ok;
            parity_err <= !par_off_q && par_bad;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       dr_clr_n,
  input logic [7:0] rx_data,
  input logic       data_ready,
  input logic       overrun,
  input logic       frame_err,
  input logic       parity_err,
  input logic [1:0] len_q
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (rx_data == 8'd0 && !data_ready && !overrun && !frame_err && !parity_err));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> ((rx_data >> (32'd5 + 32'(len_q))) == 8'd0));

  p_data_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $stable(rx_data));

  p_overrun_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(overrun));

  p_clear_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (!dr_clr_n && !tick) |=> !data_ready);

  p_flags_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(frame_err) && $stable(parity_err)));

  p_ready_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(tick));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .dr_clr_n(dr_clr_n),
  .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
  .frame_err(frame_err), .parity_err(parity_err), .len_q(len_q)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic rx_in = 1'b1;
  logic cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'd0;
  logic cfg_par_off = 1'b0;
  logic cfg_par_even = 1'b0;
  logic dr_clr_n = 1'b1;
  logic [7:0] rx_data;
  logic data_ready, overrun, frame_err, parity_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  uart_rx_core u_uart_rx_core (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in), .cfg_load(cfg_load),
    .cfg_len(cfg_len), .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
    .dr_clr_n(dr_clr_n), .rx_data(rx_data), .data_ready(data_ready),
    .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv + 1) % TDIV;
      tick = (tdiv == 0);
    end
  end

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'((9'd1 << (5 + len)) - 9'd1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] len, input logic even);
    return (^(d & mask_of(len))) ^ !even;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic poff, input logic even);
    cfg_len = len; cfg_par_off = poff; cfg_par_even = even;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic clear_dr();
    dr_clr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    dr_clr_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic poff,
                      input logic even, input logic badpar, input logic badstop);
    rx_in = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 5 + int'(len); i++) begin
      rx_in = d[i];
      wait_ticks(16);
    end
    if (!poff) begin
      rx_in = par_of(d, len, even) ^ badpar;
      wait_ticks(16);
    end
    rx_in = !badstop;
    wait_ticks(16);
    rx_in = 1'b1;
  endtask

  task automatic check_frame(input logic [7:0] d, input logic [1:0] len, input logic poff,
                             input logic badpar, input logic badstop, input logic exp_ov);
    chk("R3 data", rx_data, d & mask_of(len));
    chk("R8 ready", {7'd0, data_ready}, 8'd1);
    chk("R4 parity", {7'd0, parity_err}, {7'd0, !poff && badpar});
    chk("R5 framing", {7'd0, frame_err}, {7'd0, badstop});
    chk("R6 overrun", {7'd0, overrun}, {7'd0, exp_ov});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    logic cl_len_dummy;
    void'($urandom(32'h1f3a));
    repeat (8) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 data", rx_data, 8'h00);
    chk("R1 flags", {4'd0, data_ready, overrun, frame_err, parity_err}, 8'h00);

    set_cfg(2'd3, 1'b0, 1'b1);
    wait_ticks(4);
    send(8'hA5, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    check_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);

    clear_dr();
    chk("R7 cleared", {7'd0, data_ready}, 8'd0);

    send(8'h3C, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    check_frame(8'h3C, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    clear_dr();

    send(8'h81, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    wait_ticks(6);
    check_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_dr();

    set_cfg(2'd0, 1'b1, 1'b0);
    wait_ticks(4);
    send(8'hFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame(8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3 upper zero", rx_data & 8'hE0, 8'h00);
    clear_dr();

    snap = rx_data;
    rx_in = 1'b0;
    wait_ticks(3);
    rx_in = 1'b1;
    wait_ticks(30);
    chk("R2 glitch data", rx_data, snap);
    chk("R2 glitch flags", {4'd0, data_ready, overrun, frame_err, parity_err}, 8'h00);
    send(8'h0B, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_frame(8'h0B, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    clear_dr();

    cfg_len = 2'd3; cfg_par_off = 1'b0; cfg_par_even = 1'b1;
    wait_ticks(4);
    send(8'h16, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_frame(8'h16, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 format kept", rx_data, 8'h16);
    clear_dr();

    set_cfg(2'd2, 1'b0, 1'b0);
    wait_ticks(4);
    send(8'h55, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h2A, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check_frame(8'h2A, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 back to back", rx_data, 8'h2A);
    clear_dr();
    send(8'h7E, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check_frame(8'h7E, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 data", rx_data, 8'h00);
    chk("R10 flags", {4'd0, data_ready, overrun, frame_err, parity_err}, 8'h00);
    wait_ticks(4);
    send(8'h13, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_frame(8'h13, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    clear_dr();

    begin
      logic [1:0] len = 2'd0;
      logic poff = 1'b0;
      logic even = 1'b0;
      logic pending = 1'b0;
      for (int n = 0; n < 40; n++) begin
        logic [7:0] d;
        logic bp, bs, skip;
        if (n % 8 == 0) begin
          len = 2'($urandom_range(0, 3));
          poff = 1'($urandom_range(0, 1));
          even = 1'($urandom_range(0, 1));
          set_cfg(len, poff, even);
          wait_ticks(2);
        end
        d = 8'($urandom);
        bp = ($urandom_range(0, 5) == 0);
        bs = ($urandom_range(0, 7) == 0);
        skip = (n > 0) && ($urandom_range(0, 3) == 0);
        if (!skip) clear_dr();
        send(d, len, poff, even, bp, bs);
        if (bs) wait_ticks(6);
        check_frame(d, len, poff, bp, bs, skip && pending);
        pending = 1'b1;
        wait_ticks($urandom_range(0, 5));
      end
    end

    cl_len_dummy = 1'b0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule